// File: doc/BRIEF.md
# Prefix-Mode Instruction Fetch Decoder

This block is the front end of a byte-coded 16-bit processor. It keeps a one-byte prefetch register, called the pipe, that holds the next opcode. It also keeps a 16-bit program counter that addresses program memory. Program memory answers combinationally in the same cycle. Each cycle the block presents a 10-bit dispatch index to the execute stage. The index is formed from two sticky mode bits and the pipe opcode. Alongside it the block presents the current 4-bit source and destination register selectors.

When the execute stage reports that the issued opcode is done, the block advances. It does so only when it is not halted and no host load of the program counter is pending. On an advance it takes the opcode out of the pipe, refills the pipe from memory at the program counter and steps the counter. The execute stage also reports the class of the finished opcode. That class decides how the mode bits, the register-select flag and the selectors change.

Prefix opcodes set mode bits that accumulate across prefix bytes. Register-select opcodes choose the operand registers for the following opcode. A branch loads a target relative to the address of its delay-slot byte.

Top module: `prefix_fetch_decoder`

## Requirements
- R1: After reset the program counter is 0x0000, the pipe holds opcode 0x01, the dispatch index is 0x001, both selectors are 0 and the select flag is clear.
- R2: The dispatch index is {modeHi, modeLo, pipe opcode}. Bit 9 is the second mode bit, bit 8 is the first mode bit, and bits 7:0 are the opcode.
- R3: On an advance the pipe is loaded with memRdata read at memAddr. The program counter then increments by one, wrapping from 0xFFFF to 0x0000.
- R4: Class codes: 0 normal, 1 prefix-lo, 2 prefix-hi, 3 prefix-both, 4 select-both, 5 select-source, 6 select-dest, 7 branch. A prefix class sets its mode bit(s) and leaves every other mode bit, the flag and both selectors unchanged. Prefixes therefore accumulate.
- R5: A normal class clears both mode bits and the select flag, and returns both selectors to 0.
- R6: The select-both class sets the select flag and loads both selectors with bits 3:0 of the issued opcode. It keeps both mode bits.
- R7: With the flag clear, select-source loads only the source selector and select-dest loads only the destination selector, each from opcode bits 3:0, and nothing else changes. With the flag set, either class behaves as normal (R5).
- R8: A branch clears as in R5 and loads the pipe with the delay-slot byte. It sets the program counter to the delay-slot address plus the sign-extended 8-bit brOffset.
- R9: While halt is high, or exDone is low, the pipe, the program counter, the mode bits, the flag and the selectors all hold.
- R10: pcWrEn loads pcWrData into the program counter with priority over an advance. It changes nothing else that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt | input | 1 | Stall fetch and decode |
| exDone | input | 1 | Issued opcode completes this cycle |
| exKind | input | 3 | Class of the completing opcode (R4 codes) |
| brOffset | input | 8 | Signed branch displacement |
| pcWrEn | input | 1 | Host load of the program counter |
| pcWrData | input | 16 | Value for a host load |
| memAddr | output | 16 | Program memory address (program counter) |
| memRdata | input | 8 | Program memory byte at memAddr |
| dispatchIdx | output | 10 | {modeHi, modeLo, opcode} |
| srcSel | output | 4 | Source register selector |
| dstSel | output | 4 | Destination register selector |
| bFlag | output | 1 | Register-select flag |

## Verification
A scoreboard drives one opcode class per cycle against a memory whose bytes depend on their address. Runs of normal steps confirm the fetch order. Stacked prefixes separate accumulation from overwrite. A select-both opcode followed by select-source and select-dest shows whether the flag changes their meaning. A backward branch checks the delay-slot base, and a host load at 0xFFFF checks the counter wrap. Halt cycles and cycles with exDone low placed between mode-changing steps show that nothing leaks through a stall.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  typedef enum logic [2:0] {
    KIND_NORMAL = 3'd0,
    KIND_PFX_LO = 3'd1,
    KIND_PFX_HI = 3'd2,
    KIND_PFX_BOTH = 3'd3,
    KIND_SEL_BOTH = 3'd4,
    KIND_SEL_SRC = 3'd5,
    KIND_SEL_DST = 3'd6,
    KIND_BRANCH = 3'd7
  } instKind_t;

  // strobes from mode control to fetch datapath
  typedef struct packed {
    logic hostLoad;
    logic advance;
    logic jump;
  } fetchCtrl_t;

endpackage

// File: rtl/pfd_fetch_path.sv
module pfd_fetch_path
  import pfd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OP_W = 8,
  parameter int OFF_W = 8,
  parameter int MODE_W = 2,
  parameter logic [OP_W-1:0] RESET_OP = 8'h01
) (
  input  logic clk,
  input  logic rst_n,
  input  fetchCtrl_t ctrl,
  input  logic [OFF_W-1:0] brOffset,
  input  logic [ADDR_W-1:0] pcWrData,
  input  logic [OP_W-1:0] memRdata,
  input  logic [MODE_W-1:0] modeBits,
  output logic [ADDR_W-1:0] memAddr,
  output logic [OP_W-1:0] opcode,
  output logic [MODE_W+OP_W-1:0] dispatchIdx
);

  localparam int EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] pcReg;
  logic [OP_W-1:0] pipeReg;
  logic [ADDR_W-1:0] offsetExt;
  logic [ADDR_W-1:0] pcNext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign offsetExt = {{EXT_W{brOffset[OFF_W-1]}}, brOffset};
    end else begin : g_trunc
      assign offsetExt = brOffset[ADDR_W-1:0];
    end
  endgenerate

  // branch target is relative to the delay-slot address, i.e. the current pc
  always_comb begin
    if (ctrl.jump) pcNext = pcReg + offsetExt;
    else           pcNext = pcReg + ADDR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcReg   <= '0;
      pipeReg <= RESET_OP;
    end else if (ctrl.hostLoad) begin
      pcReg <= pcWrData;
    end else if (ctrl.advance) begin
      pipeReg <= memRdata;
      pcReg   <= pcNext;
    end
  end

  assign memAddr = pcReg;
  assign opcode = pipeReg;
  assign dispatchIdx = {modeBits, pipeReg};

endmodule

// File: rtl/pfd_mode_ctrl.sv
module pfd_mode_ctrl
  import pfd_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt,
  input  logic exDone,
  input  logic [2:0] exKind,
  input  logic pcWrEn,
  input  logic [SEL_W-1:0] opLow,
  output fetchCtrl_t ctrl,
  output logic [1:0] modeBits,
  output logic bFlag,
  output logic [SEL_W-1:0] srcSel,
  output logic [SEL_W-1:0] dstSel
);

  instKind_t kind;
  logic advance;
  logic clearAll;
  logic modeLo, modeHi, bReg;
  logic [SEL_W-1:0] srcReg, dstReg;

  assign kind = instKind_t'(exKind);
  assign advance = !halt && exDone && !pcWrEn;

  always_comb begin
    ctrl.hostLoad = pcWrEn;
    ctrl.advance  = advance;
    ctrl.jump     = advance && (kind == KIND_BRANCH);
  end

  always_comb begin
    case (kind)
      KIND_NORMAL, KIND_BRANCH: clearAll = 1'b1;
      KIND_SEL_SRC, KIND_SEL_DST: clearAll = bReg;
      default: clearAll = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeLo <= 1'b0;
      modeHi <= 1'b0;
      bReg   <= 1'b0;
      srcReg <= '0;
      dstReg <= '0;
    end else if (advance) begin
      if (clearAll) begin
        modeLo <= 1'b0;
        modeHi <= 1'b0;
        bReg   <= 1'b0;
        srcReg <= '0;
        dstReg <= '0;
      end else begin
        case (kind)
          KIND_PFX_LO:   modeLo <= 1'b1;
          KIND_PFX_HI:   modeHi <= 1'b1;
          KIND_PFX_BOTH: begin
            modeLo <= 1'b1;
            modeHi <= 1'b1;
          end
          KIND_SEL_BOTH: begin
            bReg   <= 1'b1;
            srcReg <= opLow;
            dstReg <= opLow;
          end
          KIND_SEL_SRC:  srcReg <= opLow;
          KIND_SEL_DST:  dstReg <= opLow;
          default: ;
        endcase
      end
    end
  end

  assign modeBits = {modeHi, modeLo};
  assign bFlag = bReg;
  assign srcSel = srcReg;
  assign dstSel = dstReg;

endmodule

// File: rtl/prefix_fetch_decoder.sv
module prefix_fetch_decoder
  import pfd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OP_W = 8,
  parameter int OFF_W = 8,
  parameter int SEL_W = 4,
  parameter logic [OP_W-1:0] RESET_OP = 8'h01
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt,
  input  logic exDone,
  input  logic [2:0] exKind,
  input  logic [OFF_W-1:0] brOffset,
  input  logic pcWrEn,
  input  logic [ADDR_W-1:0] pcWrData,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [OP_W-1:0] memRdata,
  output logic [OP_W+1:0] dispatchIdx,
  output logic [SEL_W-1:0] srcSel,
  output logic [SEL_W-1:0] dstSel,
  output logic bFlag
);

  fetchCtrl_t ctrl;
  logic [1:0] modeBits;
  logic [OP_W-1:0] opcode;

  pfd_mode_ctrl #(.SEL_W(SEL_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .halt(halt), .exDone(exDone), .exKind(exKind),
    .pcWrEn(pcWrEn), .opLow(opcode[SEL_W-1:0]), .ctrl(ctrl),
    .modeBits(modeBits), .bFlag(bFlag), .srcSel(srcSel), .dstSel(dstSel)
  );

  pfd_fetch_path #(
    .ADDR_W(ADDR_W), .OP_W(OP_W), .OFF_W(OFF_W), .MODE_W(2), .RESET_OP(RESET_OP)
  ) path_i (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .brOffset(brOffset),
    .pcWrData(pcWrData), .memRdata(memRdata), .modeBits(modeBits),
    .memAddr(memAddr), .opcode(opcode), .dispatchIdx(dispatchIdx)
  );

endmodule

// File: rtl/pfd_checker.sv
module pfd_checker #(
  parameter int ADDR_W = 16,
  parameter int OP_W = 8,
  parameter int OFF_W = 8,
  parameter int SEL_W = 4
) (
  input logic clk,
  input logic rst_n,
  input logic halt,
  input logic exDone,
  input logic [2:0] exKind,
  input logic [OFF_W-1:0] brOffset,
  input logic pcWrEn,
  input logic [ADDR_W-1:0] pcWrData,
  input logic [ADDR_W-1:0] memAddr,
  input logic [OP_W-1:0] memRdata,
  input logic [OP_W+1:0] dispatchIdx,
  input logic [SEL_W-1:0] srcSel,
  input logic [SEL_W-1:0] dstSel,
  input logic bFlag
);

  logic step;
  logic [ADDR_W-1:0] offExt;
  assign step = !halt && exDone && !pcWrEn;
  assign offExt = ADDR_W'($signed(brOffset));

  // R3: pipe refill from memory and sequential address
  p_fetch_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && exKind != 3'd7) |=> (dispatchIdx[OP_W-1:0] == $past(memRdata)) &&
                                 (memAddr == $past(memAddr) + ADDR_W'(1)));

  // R9: stall holds all visible state
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pcWrEn && (halt || !exDone)) |=> $stable(dispatchIdx) && $stable(memAddr) &&
                                       $stable(srcSel) && $stable(dstSel) && $stable(bFlag));

  // R5: normal class clears modes, flag and selectors
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && exKind == 3'd0) |=> (dispatchIdx[OP_W+1:OP_W] == 2'b00) && !bFlag &&
                                 (srcSel == '0) && (dstSel == '0));

  // R4: low prefix sets bit 8 and keeps bit 9
  p_prefix_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && exKind == 3'd1) |=> dispatchIdx[OP_W] &&
                                 (dispatchIdx[OP_W+1] == $past(dispatchIdx[OP_W+1])));

  // R6: select-both loads selectors from the issued opcode
  p_select_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && exKind == 3'd4) |=> bFlag && (srcSel == $past(dispatchIdx[SEL_W-1:0])) &&
                                 (dstSel == $past(dispatchIdx[SEL_W-1:0])));

  // R8: branch target relative to delay-slot address
  p_branch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && exKind == 3'd7) |=> (memAddr == $past(memAddr) + $past(offExt)) &&
                                 (dispatchIdx[OP_W-1:0] == $past(memRdata)));

  // R10: host load of the program counter
  p_host_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pcWrEn |=> (memAddr == $past(pcWrData)) && $stable(dispatchIdx) && $stable(bFlag));

endmodule

bind prefix_fetch_decoder pfd_checker #(
  .ADDR_W(ADDR_W), .OP_W(OP_W), .OFF_W(OFF_W), .SEL_W(SEL_W)
) chk_i (.*);

// File: tb/prefix_fetch_decoder_tb_top.sv
module prefix_fetch_decoder_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt = 1'b0;
  logic exDone = 1'b0;
  logic [2:0] exKind = 3'd0;
  logic [7:0] brOffset = 8'd0;
  logic pcWrEn = 1'b0;
  logic [15:0] pcWrData = 16'd0;
  logic [15:0] memAddr;
  logic [7:0] memRdata;
  logic [9:0] dispatchIdx;
  logic [3:0] srcSel, dstSel;
  logic bFlag;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] memFn(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction
  assign memRdata = memFn(memAddr);

  prefix_fetch_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .halt(halt), .exDone(exDone), .exKind(exKind),
    .brOffset(brOffset), .pcWrEn(pcWrEn), .pcWrData(pcWrData), .memAddr(memAddr),
    .memRdata(memRdata), .dispatchIdx(dispatchIdx), .srcSel(srcSel),
    .dstSel(dstSel), .bFlag(bFlag)
  );

  typedef struct {
    int due;
    logic [9:0] idx;
    logic [3:0] src, dst;
    logic b;
    logic [15:0] addr;
    string tag;
  } expItem_t;
  expItem_t sbq[$];

  // reference model state
  logic [15:0] mPc = 16'h0000;
  logic [7:0] mPipe = 8'h01;
  logic mLo = 0, mHi = 0, mB = 0;
  logic [3:0] mSrc = 0, mDst = 0;

  task automatic drive(input logic [2:0] kind, input logic [7:0] off, input logic h,
                       input logic d, input logic wr, input logic [15:0] wd,
                       input string tag);
    expItem_t it;
    logic clr;
    @(posedge clk);
    #1;
    exKind = kind; brOffset = off; halt = h; exDone = d; pcWrEn = wr; pcWrData = wd;
    if (wr) mPc = wd;
    else if (!h && d) begin
      clr = (kind == 3'd0) || (kind == 3'd7) || ((kind == 3'd5 || kind == 3'd6) && mB);
      if (clr) begin
        mLo = 0; mHi = 0; mB = 0; mSrc = 0; mDst = 0;
      end else begin
        case (kind)
          3'd1: mLo = 1;
          3'd2: mHi = 1;
          3'd3: begin mLo = 1; mHi = 1; end
          3'd4: begin mB = 1; mSrc = mPipe[3:0]; mDst = mPipe[3:0]; end
          3'd5: mSrc = mPipe[3:0];
          3'd6: mDst = mPipe[3:0];
          default: ;
        endcase
      end
      mPipe = memFn(mPc);
      mPc = (kind == 3'd7) ? mPc + {{8{off[7]}}, off} : mPc + 16'd1;
    end
    it.due = cyc + 1;
    it.idx = {mHi, mLo, mPipe};
    it.src = mSrc; it.dst = mDst; it.b = mB; it.addr = mPc; it.tag = tag;
    sbq.push_back(it);
  endtask

  // monitor: compare at the falling edge after the edge that produced the result
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      expItem_t e;
      e = sbq.pop_front();
      checks++;
      if (dispatchIdx !== e.idx || srcSel !== e.src || dstSel !== e.dst ||
          bFlag !== e.b || memAddr !== e.addr) begin
        fails++;
        $display("FAIL %s: got idx=%h src=%h dst=%h b=%b pc=%h exp idx=%h src=%h dst=%h b=%b pc=%h",
                 e.tag, dispatchIdx, srcSel, dstSel, bFlag, memAddr,
                 e.idx, e.src, e.dst, e.b, e.addr);
      end
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (dispatchIdx !== 10'h001 || memAddr !== 16'h0 || srcSel !== 0 || dstSel !== 0 || bFlag !== 0) begin
      fails++;
      $display("FAIL R1: got idx=%h pc=%h src=%h dst=%h b=%b exp idx=001 pc=0000 src=0 dst=0 b=0",
               dispatchIdx, memAddr, srcSel, dstSel, bFlag);
    end
    // R3 sequential normal fetch
    drive(3'd0, 0, 0, 1, 0, 0, "R3 normal");
    drive(3'd0, 0, 0, 1, 0, 0, "R3 normal");
    // R4/R2 prefix accumulation
    drive(3'd1, 0, 0, 1, 0, 0, "R4 prefix lo / R2 bit8");
    drive(3'd2, 0, 0, 1, 0, 0, "R4 accumulate hi / R2 bit9");
    drive(3'd0, 0, 0, 0, 0, 0, "R9 exDone low holds mode");
    drive(3'd0, 0, 1, 1, 0, 0, "R9 halt holds mode");
    drive(3'd0, 0, 0, 1, 0, 0, "R5 normal clears");
    drive(3'd3, 0, 0, 1, 0, 0, "R4 prefix both");
    // R6 select then R7 with flag set
    drive(3'd4, 0, 0, 1, 0, 0, "R6 select both keeps mode");
    drive(3'd5, 0, 1, 1, 0, 0, "R9 halt keeps selectors");
    drive(3'd5, 0, 0, 1, 0, 0, "R7 select-src with flag acts normal");
    // R7 without flag
    drive(3'd5, 0, 0, 1, 0, 0, "R7 select-src");
    drive(3'd6, 0, 0, 1, 0, 0, "R7 select-dst");
    drive(3'd2, 0, 0, 1, 0, 0, "R4 prefix keeps selectors");
    drive(3'd6, 0, 0, 1, 0, 0, "R7 select-dst keeps mode");
    // R8 branches
    drive(3'd7, 8'hF0, 0, 1, 0, 0, "R8 backward branch");
    drive(3'd0, 0, 0, 1, 0, 0, "R8 delay slot then target");
    drive(3'd7, 8'h23, 0, 1, 0, 0, "R8 forward branch");
    drive(3'd0, 0, 0, 1, 0, 0, "R8 target fetch");
    // R10 host load with priority, and wrap
    drive(3'd1, 0, 0, 1, 1, 16'hFFFF, "R10 host load beats advance");
    drive(3'd0, 0, 0, 1, 0, 0, "R3 wrap 0xFFFF");
    drive(3'd0, 0, 0, 1, 0, 0, "R3 after wrap");
    drive(3'd0, 0, 1, 1, 1, 16'h1234, "R10 host load during halt");
    drive(3'd4, 0, 0, 1, 0, 0, "R6 select from new stream");
    drive(3'd0, 0, 0, 0, 0, 0, "R9 idle");
    repeat (4) @(posedge clk);
    finishRun();
  end

endmodule